// File: doc/BRIEF.md
# Fine-Grained Multithreaded Warp Scheduler

This block decides, every cycle, which warp of a SIMT shader core may send its next instruction into the shared pipeline. Many thread groups are interleaved on one pipeline. Each warp carries a small state (idle, ready, in pipeline, waiting on memory), and the scheduler grants one eligible warp per cycle in rotating order, so no warp is starved.

Stalls are handled by removing warps from the candidate set rather than by stalling the pipeline. A warp that has issued is held out until its completion event comes back, so a warp never has two instructions in flight. That rule replaces a register dependency scoreboard and makes forwarding between stages unnecessary. A completed blocking load parks the warp until its memory response arrives, and the other warps keep issuing in the meantime.

Top module: `warp_sched`

## Requirements
- R1: While reset is active all warps are idle and the rotation pointer is warp 0; after release, `issue_valid_o` stays low until some warp becomes eligible.
- R2: An idle warp whose `instr_valid_i` bit is high becomes ready one cycle later. A ready warp whose bit is low is not eligible in that cycle and returns to idle at the next edge. A warp is eligible only when it is ready and its bit is high.
- R3: `issue_valid_o` is high in exactly the cycles with at least one eligible warp. `issue_wid_o` is then the first eligible warp found when scanning upward from the pointer with wrap-around. Both outputs depend on the current state and on the current `instr_valid_i`.
- R4: After a grant to warp g the pointer becomes g+1, or 0 if g is the last warp. In a cycle without a grant it holds its value.
- R5: A granted warp is in the pipeline from the next cycle. It is not eligible again until a completion event for it arrives.
- R6: A completion event (`cmpl_valid_i`, `cmpl_wid_i`) with `cmpl_is_load_i` low, for a warp in the pipeline, makes that warp ready if its instruction-valid bit is high and idle otherwise. The warp can be granted from the next cycle on.
- R7: A completion event with `cmpl_is_load_i` high, for a warp in the pipeline, puts that warp into memory wait. The warp is not granted until its memory response arrives.
- R8: A memory response (`mem_rsp_valid_i`, `mem_rsp_wid_i`) for a warp in memory wait makes that warp ready if its instruction-valid bit is high and idle otherwise, starting with the next cycle.
- R9: A completion for a warp that is not in the pipeline, or a response for a warp that is not in memory wait, has no effect. This includes the warp being granted in that same cycle.
- R10: A warp that stays eligible is granted within NUM_WARPS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | NUM_WARPS | Per-warp flag: a decoded instruction is waiting |
| cmpl_valid_i | input | 1 | Pipeline completion event strobe |
| cmpl_wid_i | input | WID_W | Warp that completed |
| cmpl_is_load_i | input | 1 | Completed instruction was a blocking load |
| mem_rsp_valid_i | input | 1 | Memory response event strobe |
| mem_rsp_wid_i | input | WID_W | Warp whose memory request returned |
| issue_valid_o | output | 1 | A warp is granted issue this cycle |
| issue_wid_o | output | WID_W | Granted warp |

## Verification
The grant outputs are combinational in the current warp states and in `instr_valid_i`. Completion events, memory responses and a grant change a warp's state at the next clock edge, so their effect on eligibility appears one cycle after the stimulus. An idle warp that sees its valid flag is first granted one cycle later. The bench drives all inputs at the falling edge and samples the grant 1 ns later, while the inputs are stable. It advances its behavioural model of warp states and pointer at the rising edge, using the same inputs and the grant it predicted. Directed phases cover reset, the valid-flag transitions, pointer wrap, the completion and load/response paths, and ignored events. These are followed by a long random run that also tracks how long each warp has been waiting.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  typedef enum logic [1:0] {
    WS_IDLE    = 2'd0,
    WS_READY   = 2'd1,
    WS_INPIPE  = 2'd2,
    WS_MEMWAIT = 2'd3
  } warp_state_e;
endpackage

// File: rtl/warp_state_cell.sv
module warp_state_cell
  import warp_sched_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        instr_valid_i,
  input  logic        grant_i,
  input  logic        cmpl_hit_i,
  input  logic        cmpl_is_load_i,
  input  logic        rsp_hit_i,
  output logic        eligible_o,
  output warp_state_e state_o
);
  warp_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:    if (instr_valid_i) state_d = WS_READY;
      WS_READY: begin
        if (grant_i)             state_d = WS_INPIPE;
        else if (!instr_valid_i) state_d = WS_IDLE;
      end
      WS_INPIPE: begin
        if (cmpl_hit_i) begin
          if (cmpl_is_load_i)     state_d = WS_MEMWAIT;
          else if (instr_valid_i) state_d = WS_READY;
          else                    state_d = WS_IDLE;
        end
      end
      WS_MEMWAIT: begin
        if (rsp_hit_i) state_d = instr_valid_i ? WS_READY : WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WS_IDLE;
    else         state_q <= state_d;
  end

  assign eligible_o = (state_q == WS_READY) && instr_valid_i;
  assign state_o    = state_q;
endmodule

// File: rtl/warp_rr_arbiter.sv
module warp_rr_arbiter #(
  parameter int unsigned NUM_REQ = 32,
  localparam int unsigned IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               gnt_valid_o,
  output logic [IDX_W-1:0]   gnt_idx_o,
  output logic [IDX_W-1:0]   ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REQ - 1);

  logic [IDX_W-1:0] ptr_q;

  // scan upward from the pointer, first hit wins
  always_comb begin
    int unsigned      pos;
    logic [IDX_W-1:0] pos_idx;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int unsigned k = 0; k < NUM_REQ; k++) begin
      pos = int'(ptr_q) + k;
      if (pos >= NUM_REQ) pos = pos - NUM_REQ;
      pos_idx = IDX_W'(pos);
      if (!gnt_valid_o && req_i[pos_idx]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = pos_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (gnt_valid_o) ptr_q <= (gnt_idx_o == LAST) ? '0 : gnt_idx_o + 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 32,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] instr_valid_i,
  input  logic                 cmpl_valid_i,
  input  logic [WID_W-1:0]     cmpl_wid_i,
  input  logic                 cmpl_is_load_i,
  input  logic                 mem_rsp_valid_i,
  input  logic [WID_W-1:0]     mem_rsp_wid_i,
  output logic                 issue_valid_o,
  output logic [WID_W-1:0]     issue_wid_o
);
  logic [NUM_WARPS-1:0]        eligible;
  warp_state_e [NUM_WARPS-1:0] warp_state;
  logic [WID_W-1:0]            rr_ptr;
  logic                        gnt_valid;
  logic [WID_W-1:0]            gnt_idx;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    logic grant_w, cmpl_hit_w, rsp_hit_w;
    assign grant_w    = gnt_valid && (gnt_idx == WID_W'(w));
    assign cmpl_hit_w = cmpl_valid_i && (cmpl_wid_i == WID_W'(w));
    assign rsp_hit_w  = mem_rsp_valid_i && (mem_rsp_wid_i == WID_W'(w));

    warp_state_cell u_cell (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .instr_valid_i (instr_valid_i[w]),
      .grant_i       (grant_w),
      .cmpl_hit_i    (cmpl_hit_w),
      .cmpl_is_load_i(cmpl_is_load_i),
      .rsp_hit_i     (rsp_hit_w),
      .eligible_o    (eligible[w]),
      .state_o       (warp_state[w])
    );
  end

  warp_rr_arbiter #(.NUM_REQ(NUM_WARPS)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (eligible),
    .gnt_valid_o(gnt_valid),
    .gnt_idx_o  (gnt_idx),
    .ptr_o      (rr_ptr)
  );

  assign issue_valid_o = gnt_valid;
  assign issue_wid_o   = gnt_idx;
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk
  import warp_sched_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 32,
  localparam int unsigned WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int unsigned CNT_W    = WID_W + 1
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       issue_valid_i,
  input logic [WID_W-1:0]           issue_wid_i,
  input logic [NUM_WARPS-1:0]       elig_i,
  input logic [NUM_WARPS-1:0][1:0]  state_i,
  input logic [WID_W-1:0]           ptr_i,
  input logic                       cmpl_valid_i,
  input logic [WID_W-1:0]           cmpl_wid_i,
  input logic                       cmpl_is_load_i,
  input logic                       rsp_valid_i,
  input logic [WID_W-1:0]           rsp_wid_i
);
  localparam logic [WID_W-1:0] LAST = WID_W'(NUM_WARPS - 1);

  a_r3_grant_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |-> elig_i[issue_wid_i]);

  a_r5_granted_in_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |=> state_i[$past(issue_wid_i)] == WS_INPIPE);

  a_r4_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i |=> ptr_i == (($past(issue_wid_i) == LAST) ? '0 : $past(issue_wid_i) + 1'b1));

  a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_i |=> $stable(ptr_i));

  a_r7_load_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && cmpl_is_load_i && state_i[cmpl_wid_i] == WS_INPIPE)
      |=> state_i[$past(cmpl_wid_i)] == WS_MEMWAIT);

  a_r8_rsp_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_i && state_i[rsp_wid_i] == WS_MEMWAIT)
      |=> state_i[$past(rsp_wid_i)] != WS_MEMWAIT);

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_fair
    logic [CNT_W-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q <= '0;
      else if (elig_i[w] && !(issue_valid_i && issue_wid_i == WID_W'(w)))
        wait_q <= (wait_q == '1) ? wait_q : wait_q + 1'b1;
      else wait_q <= '0;
    end
    a_r10_bounded_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q <= CNT_W'(NUM_WARPS - 1));
  end
endmodule

bind warp_sched warp_sched_chk #(.NUM_WARPS(NUM_WARPS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_valid_i (issue_valid_o),
  .issue_wid_i   (issue_wid_o),
  .elig_i        (eligible),
  .state_i       (warp_state),
  .ptr_i         (rr_ptr),
  .cmpl_valid_i  (cmpl_valid_i),
  .cmpl_wid_i    (cmpl_wid_i),
  .cmpl_is_load_i(cmpl_is_load_i),
  .rsp_valid_i   (mem_rsp_valid_i),
  .rsp_wid_i     (mem_rsp_wid_i)
);

// File: tb/warp_sched_bench.sv
`timescale 1ns/1ps
module warp_sched_bench;
  localparam int N  = 32;
  localparam int WW = $clog2(N);
  localparam int M_IDLE = 0, M_READY = 1, M_PIPE = 2, M_MEM = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  ivalid = '0;
  logic          cv = 1'b0, cl = 1'b0, rv = 1'b0;
  logic [WW-1:0] cw = '0, rw = '0;
  logic          iss_v;
  logic [WW-1:0] iss_w;

  always #4 clk = ~clk;

  warp_sched #(.NUM_WARPS(N)) u_warp_sched (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(ivalid),
    .cmpl_valid_i(cv), .cmpl_wid_i(cw), .cmpl_is_load_i(cl),
    .mem_rsp_valid_i(rv), .mem_rsp_wid_i(rw),
    .issue_valid_o(iss_v), .issue_wid_o(iss_w));

  int st [N];
  int wt [N];
  int ptr;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", t, what, act, exp);
    end
  endtask

  function automatic int pick();
    for (int k = 0; k < N; k++) begin
      int j = (ptr + k) % N;
      if (st[j] == M_READY && ivalid[j]) return j;
    end
    return -1;
  endfunction

  // one clock: compare at negedge+1, advance model at posedge
  task automatic cycle();
    int g;
    #1;
    g = pick();
    chk(iss_v == (g >= 0), tag, "issue_valid", int'(iss_v), int'(g >= 0));
    if (g >= 0) chk(int'(iss_w) == g, tag, "issue_wid", int'(iss_w), g);
    for (int w = 0; w < N; w++) begin
      if (st[w] == M_READY && ivalid[w] && w != g) wt[w]++;
      else wt[w] = 0;
      if (wt[w] > N - 1) chk(1'b0, "R10", "wait cycles", wt[w], N - 1);
    end
    @(posedge clk);
    for (int w = 0; w < N; w++) begin
      case (st[w])
        M_IDLE:  if (ivalid[w]) st[w] = M_READY;
        M_READY: if (w == g) st[w] = M_PIPE; else if (!ivalid[w]) st[w] = M_IDLE;
        M_PIPE:  if (cv && int'(cw) == w) st[w] = cl ? M_MEM : (ivalid[w] ? M_READY : M_IDLE);
        default: if (rv && int'(rw) == w) st[w] = ivalid[w] ? M_READY : M_IDLE;
      endcase
    end
    if (g >= 0) ptr = (g + 1) % N;
    @(negedge clk);
    cv = 1'b0; cl = 1'b0; rv = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int w = 0; w < N; w++) begin st[w] = M_IDLE; wt[w] = 0; end
    ptr = 0;
    repeat (2) @(negedge clk);
    #1 chk(iss_v == 1'b0, "R1", "issue_valid in reset", int'(iss_v), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; run(3);

    tag = "R2";
    ivalid = 32'h0000_000F;
    run(1);
    ivalid[2] = 1'b0;
    run(4);

    tag = "R4";
    ivalid = '1;
    run(40);

    tag = "R6";
    cv = 1'b1; cw = WW'(5); cl = 1'b0; run(1);
    #1 chk(iss_v && iss_w == WW'(5), "R6", "warp 5 regranted", int'(iss_w), 5);
    run(3);

    tag = "R7";
    cv = 1'b1; cw = WW'(6); cl = 1'b1; run(1);
    run(4);
    tag = "R8";
    rv = 1'b1; rw = WW'(6); run(1);
    #1 chk(iss_v && iss_w == WW'(6), "R8", "warp 6 after response", int'(iss_w), 6);
    run(3);

    tag = "R9";
    rv = 1'b1; rw = WW'(7); run(1);      // warp 7 in pipe, not waiting
    ivalid[9] = 1'b0;
    cv = 1'b1; cw = WW'(9); run(1);      // warp 9 goes idle
    cv = 1'b1; cw = WW'(9); run(1);      // completion to idle warp
    #1 chk(iss_v == 1'b0, "R9", "no grant after stray events", int'(iss_v), 0);
    ivalid[9] = 1'b1;
    run(3);

    tag = "R3/R5";
    for (int i = 0; i < 20000; i++) begin
      int a, b;
      for (int w = 0; w < N; w++)
        if (ivalid[w]) begin if ($urandom_range(31) == 0) ivalid[w] = 1'b0; end
        else if ($urandom_range(3) == 0) ivalid[w] = 1'b1;
      a = $urandom_range(N - 1);
      cw = WW'(a);
      cl = ($urandom_range(2) == 0);
      cv = (st[a] == M_PIPE) ? ($urandom_range(3) != 0) : ($urandom_range(7) == 0);
      b = $urandom_range(N - 1);
      rw = WW'(b);
      rv = (st[b] == M_MEM) ? ($urandom_range(2) != 0) : ($urandom_range(7) == 0);
      cycle();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule